// File: doc/BRIEF.md
# Multiplexed Address and Cycle Bus Driver

This block sits between a processor core's sequencer and a shared byte-wide bidirectional bus. Each machine cycle sends a 14-bit memory address over that bus in two slices: first the low byte, then the upper six address bits packed with a 2-bit code that names the kind of cycle. After that the same wires carry a data byte, either outward (memory write, I/O command) or inward (instruction fetch, memory data read). The block does not sequence states. It takes the state the sequencer presents on each clock and decides what the bus carries in that state, whether the block drives the bus, and when it samples the bus.

Every input takes effect at a clock edge, and the bus outputs follow the registered state one clock after it is presented. The address and cycle code are captured on the edge that enters an address-low state. The outgoing data byte is captured on the edge that enters T3. Because of these captures, changes on the core inputs while the cycle is in progress do not disturb the bus. The byte read from the bus goes to the core as a one-clock `rdata_valid` pulse with the byte on `rdata`. This return path has no ready signal and so no back-pressure: the core must accept the byte in the pulse cycle, and `rdata` keeps the byte until the next capture.

Top module: `mxbus_driver`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `bus_oe`, `bus_out`, `rdata_valid` and `rdata` are all zero.
- R2: State codes on `state_i` are 0 WAIT, 1 T1, 2 T1I (interrupted T1), 3 T2, 4 T3, 5 T4, 6 T5, 7 STOPPED. One clock after T1 or T1I is presented, `bus_oe` is 1 and `bus_out` carries the low address byte.
- R3: In T2, `bus_out[5:0]` carries address bits 13:8 and `bus_out[7:6]` carries the cycle code, with `cyc_i[0]` on bit 6 and `cyc_i[1]` on bit 7. The codes are 00 fetch, 10 read (bit 7 set), 01 I/O command (bit 6 set) and 11 write.
- R4: Address and cycle code are captured only on the edge that moves into T1 or T1I from any other state. They stay unchanged through repeated address-low clocks and through T2, even when `addr_i` and `cyc_i` change.
- R5: In T3 of a write or I/O cycle, `bus_oe` is 1 and `bus_out` carries the `wdata_i` value captured on the edge that entered T3. That value is held while T3 is stretched.
- R6: In T3 of a fetch or read cycle, `bus_oe` is 0 and `bus_out` is 0.
- R7: In WAIT, STOPPED, T4 and T5, `bus_oe` is 0 and `bus_out` is 0.
- R8: On the edge that leaves T3 of a fetch or read cycle, `bus_in` is latched into `rdata`. `rdata_valid` is 1 for exactly the following clock, and `rdata` holds the byte until the next capture.
- R9: Leaving T3 of a write or I/O cycle captures nothing: `rdata_valid` stays 0 and `rdata` keeps its value.
- R10: When T3 lasts several clocks, only the `bus_in` value at the edge that ends T3 is latched. Values present during earlier T3 clocks are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 3 | Processor state for the coming clock (codes in R2) |
| addr_i | input | 14 | Memory address of the next cycle |
| cyc_i | input | 2 | Cycle code of the next cycle (codes in R3) |
| wdata_i | input | 8 | Outgoing data byte for write and I/O cycles |
| bus_in | input | 8 | Value currently seen on the shared bus |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| rdata | output | 8 | Byte captured from the bus for the core |
| rdata_valid | output | 1 | One-clock pulse marking a new `rdata` byte |

## Verification
If the address or cycle snapshot is wrong, the fault shows on `bus_out` in the first T1 or T2 clock that follows. A missed capture repeats the previous cycle's address, and a spurious capture lets a changed `addr_i` leak into T2. If the registered state or the cycle direction is wrong, the fault appears in T3 as a drive enable with the wrong polarity, visible in the same clock. A wrong end-of-T3 decision shows one clock later, either as a missing or extra `rdata_valid` pulse or as an `rdata` byte taken from an earlier or a later bus value.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  localparam int CYC_W = 2;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_T1   = 3'd1,
    ST_T1I  = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_T5   = 3'd6,
    ST_STOP = 3'd7
  } mx_state_e;

  // bit 0 travels on bus bit 6, bit 1 on bus bit 7
  typedef enum logic [1:0] {
    CY_FETCH = 2'b00,
    CY_IO    = 2'b01,
    CY_READ  = 2'b10,
    CY_WRITE = 2'b11
  } mx_cyc_e;

  function automatic logic st_is_lo(mx_state_e s);
    return (s == ST_T1) || (s == ST_T1I);
  endfunction

  function automatic logic cyc_inward(mx_cyc_e c);
    return (c == CY_FETCH) || (c == CY_READ);
  endfunction

endpackage

// File: rtl/mxbus_snap.sv
module mxbus_snap
  import mxbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W - CYC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mx_state_e         st_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mx_cyc_e           cyc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mx_state_e         st_q,
  output logic [ADDR_W-1:0] addr_q,
  output mx_cyc_e           cyc_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic enter_lo;
  logic enter_t3;

  assign enter_lo = st_is_lo(st_i) && !st_is_lo(st_q);
  assign enter_t3 = (st_i == ST_T3) && (st_q != ST_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT;
      addr_q  <= '0;
      cyc_q   <= CY_FETCH;
      wdata_q <= '0;
    end else begin
      st_q <= st_i;
      if (enter_lo) begin
        addr_q <= addr_i;
        cyc_q  <= cyc_i;
      end
      if (enter_t3) begin
        wdata_q <= wdata_i;
      end
    end
  end

  // R4: snapshot frozen during T2
  p_hold_t2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T2) |-> ($stable(addr_q) && $stable(cyc_q)));

  // R4: snapshot frozen across repeated address-low clocks
  p_hold_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_is_lo(st_q) && st_is_lo($past(st_q))) |-> ($stable(addr_q) && $stable(cyc_q)));

  // R5: outgoing byte frozen while T3 is stretched
  p_hold_wdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T3 && $past(st_q) == ST_T3) |-> $stable(wdata_q));

endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
  import mxbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W - CYC_W,
  localparam int HI_W   = DATA_W - CYC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mx_state_e         st_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  mx_cyc_e           cyc_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);

  logic [CYC_W-1:0]  cyc_bits;
  logic [DATA_W-1:0] hi_byte;

  assign cyc_bits = cyc_q;

  // upper address bits fill the low lanes, cycle code the top lanes
  for (genvar i = 0; i < DATA_W; i++) begin : g_hi
    if (i < HI_W) begin : g_addr
      assign hi_byte[i] = addr_q[DATA_W+i];
    end else begin : g_cyc
      assign hi_byte[i] = cyc_bits[i-HI_W];
    end
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = 1'b0;
    case (st_q)
      ST_T1, ST_T1I: begin
        bus_out = addr_q[DATA_W-1:0];
        bus_oe  = 1'b1;
      end
      ST_T2: begin
        bus_out = hi_byte;
        bus_oe  = 1'b1;
      end
      ST_T3: begin
        if (!cyc_inward(cyc_q)) begin
          bus_out = wdata_q;
          bus_oe  = 1'b1;
        end
      end
      default: begin
        bus_out = '0;
        bus_oe  = 1'b0;
      end
    endcase
  end

  // R6: inward T3 never drives
  p_inward_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T3 && cyc_inward(cyc_q)) |-> (!bus_oe && bus_out == '0));

  // R7: idle and execute states release the bus
  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT || st_q == ST_STOP || st_q == ST_T4 || st_q == ST_T5)
      |-> (!bus_oe && bus_out == '0));

endmodule

// File: rtl/mxbus_sample.sv
module mxbus_sample
  import mxbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mx_state_e         st_i,
  input  mx_state_e         st_q,
  input  mx_cyc_e           cyc_q,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);

  logic leave_t3;
  logic take;

  assign leave_t3 = (st_q == ST_T3) && (st_i != ST_T3);
  assign take     = leave_t3 && cyc_inward(cyc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= take;
      if (take) begin
        rdata <= bus_in;
      end
    end
  end

  // R8: single-clock pulse
  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  // R8: a pulse follows only an inward T3
  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> ($past(st_q) == ST_T3 && cyc_inward($past(cyc_q))));

  // R9: outward cycles leave the return path untouched
  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_T3 && !cyc_inward($past(cyc_q)))
      |-> (!rdata_valid && $stable(rdata)));

endmodule

// File: rtl/mxbus_driver.sv
module mxbus_driver
  import mxbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W - CYC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);

  mx_state_e         st_in;
  mx_cyc_e           cyc_in;
  mx_state_e         st_q;
  mx_cyc_e           cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign st_in  = mx_state_e'(state_i);
  assign cyc_in = mx_cyc_e'(cyc_i);

  mxbus_snap #(.DATA_W(DATA_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_i    (st_in),
    .addr_i  (addr_i),
    .cyc_i   (cyc_in),
    .wdata_i (wdata_i),
    .st_q    (st_q),
    .addr_q  (addr_q),
    .cyc_q   (cyc_q),
    .wdata_q (wdata_q)
  );

  mxbus_drive #(.DATA_W(DATA_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_q    (st_q),
    .addr_q  (addr_q),
    .cyc_q   (cyc_q),
    .wdata_q (wdata_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  mxbus_sample #(.DATA_W(DATA_W)) u_sample (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_i        (st_in),
    .st_q        (st_q),
    .cyc_q       (cyc_q),
    .bus_in      (bus_in),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

endmodule

// File: tb/mxbus_driver_tb.sv
`timescale 1ns/1ps
module mxbus_driver_tb;

  typedef struct packed {
    logic [2:0]  st;
    logic [13:0] a;
    logic [1:0]  c;
    logic [7:0]  wd;
    logic [7:0]  bi;
    logic        eoe;
    logic [7:0]  ebo;
    logic        erv;
    logic [7:0]  erd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  // states: 0 WAIT 1 T1 2 T1I 3 T2 4 T3 5 T4 6 T5 7 STOP
  // cycle: 00 fetch, 10 read, 01 io, 11 write
  localparam vec_t TBL [NV] = '{
    '{3'd1, 14'h2A5C, 2'd0, 8'h00, 8'h00, 1'b1, 8'h5C, 1'b0, 8'h00, 4'd2},  // R2 fetch low byte
    '{3'd3, 14'h3FFF, 2'd3, 8'h00, 8'h00, 1'b1, 8'h2A, 1'b0, 8'h00, 4'd3},  // R3 R4 inputs changed
    '{3'd4, 14'h3FFF, 2'd3, 8'h00, 8'h77, 1'b0, 8'h00, 1'b0, 8'h00, 4'd6},  // R6
    '{3'd4, 14'h0000, 2'd0, 8'h00, 8'h96, 1'b0, 8'h00, 1'b0, 8'h00, 4'd10}, // R10 stretched T3
    '{3'd5, 14'h0000, 2'd0, 8'h00, 8'hC3, 1'b0, 8'h00, 1'b1, 8'hC3, 4'd8},  // R8 R10 last value
    '{3'd6, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'hC3, 4'd7},  // R7 R8 pulse ends
    '{3'd1, 14'h1234, 2'd3, 8'h00, 8'h00, 1'b1, 8'h34, 1'b0, 8'hC3, 4'd2},  // R2 write cycle
    '{3'd3, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b1, 8'hD2, 1'b0, 8'hC3, 4'd3},  // R3 write code
    '{3'd4, 14'h0000, 2'd0, 8'hA5, 8'hFF, 1'b1, 8'hA5, 1'b0, 8'hC3, 4'd5},  // R5
    '{3'd4, 14'h0000, 2'd0, 8'h5A, 8'hEE, 1'b1, 8'hA5, 1'b0, 8'hC3, 4'd5},  // R5 held
    '{3'd2, 14'h3F80, 2'd2, 8'h00, 8'h44, 1'b1, 8'h80, 1'b0, 8'hC3, 4'd9},  // R9 R2 T1I
    '{3'd3, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b1, 8'hBF, 1'b0, 8'hC3, 4'd3},  // R3 read code
    '{3'd0, 14'h0000, 2'd0, 8'h00, 8'h12, 1'b0, 8'h00, 1'b0, 8'hC3, 4'd7},  // R7 wait
    '{3'd4, 14'h0000, 2'd0, 8'h00, 8'h34, 1'b0, 8'h00, 1'b0, 8'hC3, 4'd6},  // R6 read T3
    '{3'd7, 14'h0000, 2'd0, 8'h00, 8'h5E, 1'b0, 8'h00, 1'b1, 8'h5E, 4'd8},  // R8
    '{3'd7, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h5E, 4'd7},  // R7 stopped
    '{3'd1, 14'h0015, 2'd1, 8'h00, 8'h00, 1'b1, 8'h15, 1'b0, 8'h5E, 4'd2},  // R2 io cycle
    '{3'd3, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b1, 8'h40, 1'b0, 8'h5E, 4'd3},  // R3 io code
    '{3'd4, 14'h0000, 2'd0, 8'h3C, 8'h00, 1'b1, 8'h3C, 1'b0, 8'h5E, 4'd5},  // R5 io out
    '{3'd5, 14'h0000, 2'd0, 8'h00, 8'h99, 1'b0, 8'h00, 1'b0, 8'h5E, 4'd9},  // R9
    '{3'd1, 14'h00AA, 2'd0, 8'h00, 8'h00, 1'b1, 8'hAA, 1'b0, 8'h5E, 4'd4},  // R4
    '{3'd1, 14'h00BB, 2'd1, 8'h00, 8'h00, 1'b1, 8'hAA, 1'b0, 8'h5E, 4'd4},  // R4 no recapture
    '{3'd3, 14'h3FFF, 2'd3, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 8'h5E, 4'd4},  // R4 R3
    '{3'd6, 14'h0000, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h5E, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  state_i = 3'd0;
  logic [13:0] addr_i = '0;
  logic [1:0]  cyc_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  rdata;
  logic        rdata_valid;

  int nvec = 0;
  int nfail = 0;
  int ncyc = 0;

  always #4 clk = ~clk;

  mxbus_driver u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state_i),
    .addr_i      (addr_i),
    .cyc_i       (cyc_i),
    .wdata_i     (wdata_i),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

  task automatic check(input logic eoe, input logic [7:0] ebo, input logic erv,
                       input logic [7:0] erd, input string tag);
    nvec++;
    if (bus_oe !== eoe || bus_out !== ebo || rdata_valid !== erv || rdata !== erd) begin
      nfail++;
      $display("FAIL %s: got oe=%0b bus=%h rv=%0b rd=%h, expected oe=%0b bus=%h rv=%0b rd=%h",
               tag, bus_oe, bus_out, rdata_valid, rdata, eoe, ebo, erv, erd);
    end
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 5000) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles, expected under 5000", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 8'h00, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 8'h00, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      state_i = TBL[i].st;
      addr_i  = TBL[i].a;
      cyc_i   = TBL[i].c;
      wdata_i = TBL[i].wd;
      bus_in  = TBL[i].bi;
      @(posedge clk);
      @(negedge clk);
      check(TBL[i].eoe, TBL[i].ebo, TBL[i].erv, TBL[i].erd,
            $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R1: reset in the middle of a write transfer clears everything
    state_i = 3'd1; addr_i = 14'h0ABC; cyc_i = 2'd3;
    @(negedge clk);
    state_i = 3'd3;
    @(negedge clk);
    state_i = 3'd4; wdata_i = 8'h6D;
    @(negedge clk);
    check(1'b1, 8'h6D, 1'b0, 8'h5E, "R5 before mid reset");
    rst_n = 1'b0;
    #1;
    check(1'b0, 8'h00, 1'b0, 8'h00, "R1 mid-transfer reset");
    @(negedge clk);
    rst_n = 1'b1;
    state_i = 3'd0;
    @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 8'h00, "R1 after mid reset");

    // R8 R10: fetch right after reset, three-clock T3, capture only the final value
    state_i = 3'd1; addr_i = 14'h0007; cyc_i = 2'd0;
    @(negedge clk);
    check(1'b1, 8'h07, 1'b0, 8'h00, "R2 post-reset fetch");
    state_i = 3'd3;
    @(negedge clk);
    check(1'b1, 8'h00, 1'b0, 8'h00, "R3 fetch code");
    state_i = 3'd4; bus_in = 8'h01;
    @(negedge clk);
    bus_in = 8'h02;
    @(negedge clk);
    bus_in = 8'h03;
    @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 8'h00, "R10 stretched inward T3");
    state_i = 3'd1; addr_i = 14'h0100; bus_in = 8'hE7;
    @(negedge clk);
    check(1'b1, 8'h00, 1'b1, 8'hE7, "R8 R10 capture at T3 exit into T1");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule